// File: doc/BRIEF.md
# Virtual Wire Event Interrupt Controller

This block turns two groups of incoming system-event wires, already decoded from a serial host link into parallel level inputs, into latched interrupt status. Each event bit picks its own trigger rule through a three-bit code. The code is assembled from the same bit position in three separate type registers. One code gives dual-edge detection, another gives rising-edge detection, and every remaining code gives a level-high trigger. A status bit latches only when its per-bit enable is set, and software clears it by writing one to it.

A summary stage merges both groups and a link hardware-reset event into one top-level status word. That word has its own enable mask and a single interrupt output. All registers sit behind a plain 32-bit word-addressed read/write port, and reads are combinational. The group value registers return the live input levels, so firmware can read the current wire state before it decides how to respond.

Top module: `vw_event_irq`

## Requirements
- R1: After reset, every type, enable and status register reads 0 and `irq` is 0.
- R2: A bit whose code {type2,type1,type0} (offsets 0x118/0x114/0x110 for group 0, 0x128/0x124/0x120 for group 1, code bits taken from the same bit index) equals 3'b100 latches status on both a rising and a falling input transition.
- R3: Code 3'b001 latches status on a rising transition only; a falling transition leaves status unchanged.
- R4: Any other code is a level-high trigger: status is set on every cycle the input is 1, so a clear written while the input stays high does not remove the bit.
- R5: A trigger on a bit whose enable (0x094 group 0, 0x100 group 1) is 0 sets neither the group status nor the top-level status.
- R6: Group status (0x11C, 0x12C) and top status (0x008) are write-one-to-clear; writing 0 to a bit leaves it unchanged.
- R7: A status bit triggered in the same cycle as a write-one-to-clear of that bit stays set.
- R8: Top status bit 8 is set when any group-0 bit triggers, bit 22 when any group-1 bit triggers, and bit 31 on a rising edge of `hw_rst_evt`, each only if the same bit of the top enable (0x00C) is 1.
- R9: `irq` is 1 exactly when some top status bit and its top enable bit are both 1.
- R10: The group value registers (0x098, 0x104) read the live inputs. The top enable keeps only bits 31, 22 and 8. Unmapped offsets, including 0x000, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| g0_evt | input | 32 | Group-0 event wire levels |
| g1_evt | input | 32 | Group-1 event wire levels |
| hw_rst_evt | input | 1 | Link hardware-reset event level |
| reg_addr | input | 12 | Register byte offset |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A stale previous-input register shows up as a spurious or missing status bit one read after the input change. A wrong type decode shows up the same way, because every status register updates on the edge that follows the stimulus. A clear that overrides a concurrent trigger loses the bit at once, and a missing enable gate sets status and raises `irq` in the very next cycle. The top summary follows the group one cycle at most, so a broken merge is seen in the first top-status read after a group event.

// File: rtl/vw_irq_pkg.sv
package vw_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 12;

  // trigger codes, {type2, type1, type0}
  localparam logic [2:0] TRIG_BOTH = 3'b100;
  localparam logic [2:0] TRIG_RISE = 3'b001;

  // top-level summary bit positions
  localparam int unsigned TOP_G0_BIT  = 8;
  localparam int unsigned TOP_G1_BIT  = 22;
  localparam int unsigned TOP_HWR_BIT = 31;
  localparam logic [REG_W-1:0] TOP_EN_MASK =
    (REG_W'(1) << TOP_G0_BIT) | (REG_W'(1) << TOP_G1_BIT) | (REG_W'(1) << TOP_HWR_BIT);

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_TOP_STS = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_TOP_EN  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_G0_EN   = 12'h094;
  localparam logic [ADDR_W-1:0] OFS_G0_VAL  = 12'h098;
  localparam logic [ADDR_W-1:0] OFS_G0_TY0  = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_G0_TY1  = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_G0_TY2  = 12'h118;
  localparam logic [ADDR_W-1:0] OFS_G0_STS  = 12'h11C;
  localparam logic [ADDR_W-1:0] OFS_G1_EN   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_G1_VAL  = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_G1_TY0  = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_G1_TY1  = 12'h124;
  localparam logic [ADDR_W-1:0] OFS_G1_TY2  = 12'h128;
  localparam logic [ADDR_W-1:0] OFS_G1_STS  = 12'h12C;
endpackage

// File: rtl/vw_trig_detect.sv
module vw_trig_detect
  import vw_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] evt,
  input  logic [W-1:0] evt_prev,
  input  logic [W-1:0] ty0,
  input  logic [W-1:0] ty1,
  input  logic [W-1:0] ty2,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] code;
    logic       rise;
    logic       fall;
    assign code = {ty2[i], ty1[i], ty0[i]};
    assign rise = evt[i] & ~evt_prev[i];
    assign fall = ~evt[i] & evt_prev[i];
    always_comb begin
      case (code)
        TRIG_BOTH: hit[i] = rise | fall;
        TRIG_RISE: hit[i] = rise;
        default:   hit[i] = evt[i];
      endcase
    end
  end
endmodule

// File: rtl/vw_evt_group.sv
module vw_evt_group
  import vw_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     evt,
  input  logic [W-1:0]     wdata,
  input  logic             we_en,
  input  logic             we_ty0,
  input  logic             we_ty1,
  input  logic             we_ty2,
  input  logic             we_sts,
  output logic [W-1:0]     en_q,
  output logic [W-1:0]     ty0_q,
  output logic [W-1:0]     ty1_q,
  output logic [W-1:0]     ty2_q,
  output logic [W-1:0]     sts_q,
  output logic             set_any
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] sts_d;

  vw_trig_detect #(.W(W)) i_detect (
    .evt      (evt),
    .evt_prev (prev_q),
    .ty0      (ty0_q),
    .ty1      (ty1_q),
    .ty2      (ty2_q),
    .hit      (hit)
  );

  always_comb begin
    set_vec = hit & en_q;
    clr_vec = we_sts ? wdata : '0;
    sts_d   = (sts_q & ~clr_vec) | set_vec;
    set_any = |set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= evt;
      sts_q  <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (we_en) en_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ty0_q <= '0;
    else if (we_ty0) ty0_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ty1_q <= '0;
    else if (we_ty1) ty1_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ty2_q <= '0;
    else if (we_ty2) ty2_q <= wdata;
  end

  // a status bit may only appear where the enable was set
  assert_sts_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0));

  // a trigger in the clearing cycle survives
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_sts && ((set_vec & wdata) != '0)) |=>
      ((sts_q & $past(set_vec & wdata)) == $past(set_vec & wdata)));
endmodule

// File: rtl/vw_top_status.sv
module vw_top_status
  import vw_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             g0_set,
  input  logic             g1_set,
  input  logic             hw_rst_evt,
  input  logic [REG_W-1:0] wdata,
  input  logic             we_en,
  input  logic             we_sts,
  output logic [REG_W-1:0] top_en_q,
  output logic [REG_W-1:0] top_sts_q,
  output logic             irq
);
  logic             hwr_prev_q;
  logic             hwr_rise;
  logic [REG_W-1:0] set_raw;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] sts_d;
  logic [REG_W-1:0] en_d;

  always_comb begin
    hwr_rise             = hw_rst_evt & ~hwr_prev_q;
    set_raw              = '0;
    set_raw[TOP_G0_BIT]  = g0_set;
    set_raw[TOP_G1_BIT]  = g1_set;
    set_raw[TOP_HWR_BIT] = hwr_rise;
    set_vec              = set_raw & top_en_q;
    clr_vec              = we_sts ? wdata : '0;
    sts_d                = (top_sts_q & ~clr_vec) | set_vec;
    en_d                 = wdata & TOP_EN_MASK;
    irq                  = |(top_sts_q & top_en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwr_prev_q <= 1'b0;
      top_sts_q  <= '0;
    end else begin
      hwr_prev_q <= hw_rst_evt;
      top_sts_q  <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     top_en_q <= '0;
    else if (we_en) top_en_q <= en_d;
  end

  assert_hwr_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rst_evt && !hwr_prev_q && top_en_q[TOP_HWR_BIT]) |=> top_sts_q[TOP_HWR_BIT]);

  assert_g0_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (g0_set && top_en_q[TOP_G0_BIT]) |=> top_sts_q[TOP_G0_BIT]);

  assert_g1_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (g1_set && top_en_q[TOP_G1_BIT]) |=> top_sts_q[TOP_G1_BIT]);
endmodule

// File: rtl/vw_event_irq.sv
module vw_event_irq
  import vw_irq_pkg::*;
#(
  parameter int unsigned G0_W = 32,
  parameter int unsigned G1_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [G0_W-1:0]   g0_evt,
  input  logic [G1_W-1:0]   g1_evt,
  input  logic              hw_rst_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [G0_W-1:0] g0_en, g0_ty0, g0_ty1, g0_ty2, g0_sts;
  logic [G1_W-1:0] g1_en, g1_ty0, g1_ty1, g1_ty2, g1_sts;
  logic [REG_W-1:0] top_en, top_sts;
  logic g0_set, g1_set;

  logic we_g0_en, we_g0_t0, we_g0_t1, we_g0_t2, we_g0_st;
  logic we_g1_en, we_g1_t0, we_g1_t1, we_g1_t2, we_g1_st;
  logic we_top_en, we_top_st;

  always_comb begin
    we_g0_en  = reg_wen && (reg_addr == OFS_G0_EN);
    we_g0_t0  = reg_wen && (reg_addr == OFS_G0_TY0);
    we_g0_t1  = reg_wen && (reg_addr == OFS_G0_TY1);
    we_g0_t2  = reg_wen && (reg_addr == OFS_G0_TY2);
    we_g0_st  = reg_wen && (reg_addr == OFS_G0_STS);
    we_g1_en  = reg_wen && (reg_addr == OFS_G1_EN);
    we_g1_t0  = reg_wen && (reg_addr == OFS_G1_TY0);
    we_g1_t1  = reg_wen && (reg_addr == OFS_G1_TY1);
    we_g1_t2  = reg_wen && (reg_addr == OFS_G1_TY2);
    we_g1_st  = reg_wen && (reg_addr == OFS_G1_STS);
    we_top_en = reg_wen && (reg_addr == OFS_TOP_EN);
    we_top_st = reg_wen && (reg_addr == OFS_TOP_STS);
  end

  vw_evt_group #(.W(G0_W)) i_grp0 (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt     (g0_evt),
    .wdata   (reg_wdata[G0_W-1:0]),
    .we_en   (we_g0_en),
    .we_ty0  (we_g0_t0),
    .we_ty1  (we_g0_t1),
    .we_ty2  (we_g0_t2),
    .we_sts  (we_g0_st),
    .en_q    (g0_en),
    .ty0_q   (g0_ty0),
    .ty1_q   (g0_ty1),
    .ty2_q   (g0_ty2),
    .sts_q   (g0_sts),
    .set_any (g0_set)
  );

  vw_evt_group #(.W(G1_W)) i_grp1 (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt     (g1_evt),
    .wdata   (reg_wdata[G1_W-1:0]),
    .we_en   (we_g1_en),
    .we_ty0  (we_g1_t0),
    .we_ty1  (we_g1_t1),
    .we_ty2  (we_g1_t2),
    .we_sts  (we_g1_st),
    .en_q    (g1_en),
    .ty0_q   (g1_ty0),
    .ty1_q   (g1_ty1),
    .ty2_q   (g1_ty2),
    .sts_q   (g1_sts),
    .set_any (g1_set)
  );

  vw_top_status i_top (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .g0_set     (g0_set),
    .g1_set     (g1_set),
    .hw_rst_evt (hw_rst_evt),
    .wdata      (reg_wdata),
    .we_en      (we_top_en),
    .we_sts     (we_top_st),
    .top_en_q   (top_en),
    .top_sts_q  (top_sts),
    .irq        (irq)
  );

  always_comb begin
    case (reg_addr)
      OFS_TOP_STS: reg_rdata = top_sts;
      OFS_TOP_EN:  reg_rdata = top_en;
      OFS_G0_EN:   reg_rdata = REG_W'(g0_en);
      OFS_G0_VAL:  reg_rdata = REG_W'(g0_evt);
      OFS_G0_TY0:  reg_rdata = REG_W'(g0_ty0);
      OFS_G0_TY1:  reg_rdata = REG_W'(g0_ty1);
      OFS_G0_TY2:  reg_rdata = REG_W'(g0_ty2);
      OFS_G0_STS:  reg_rdata = REG_W'(g0_sts);
      OFS_G1_EN:   reg_rdata = REG_W'(g1_en);
      OFS_G1_VAL:  reg_rdata = REG_W'(g1_evt);
      OFS_G1_TY0:  reg_rdata = REG_W'(g1_ty0);
      OFS_G1_TY1:  reg_rdata = REG_W'(g1_ty1);
      OFS_G1_TY2:  reg_rdata = REG_W'(g1_ty2);
      OFS_G1_STS:  reg_rdata = REG_W'(g1_sts);
      default:     reg_rdata = '0;
    endcase
  end

  // the line must be quiet whenever nothing enabled is pending
  assert_irq_quiet_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (we_top_st && ((top_sts & ~reg_wdata) == '0) && !g0_set && !g1_set && !hw_rst_evt) |=> !irq);
endmodule

// File: tb/test_vw_event_irq.sv
`timescale 1ns/1ps
module test_vw_event_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] g0_evt = '0;
  logic [31:0] g1_evt = '0;
  logic        hw_rst_evt = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vw_event_irq i_vw_event_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .g0_evt     (g0_evt),
    .g1_evt     (g1_evt),
    .hw_rst_evt (hw_rst_evt),
    .reg_addr   (reg_addr),
    .reg_wen    (reg_wen),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq)
  );

  localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_G0 = 3'd2,
                         OP_G1 = 3'd3, OP_HW = 3'd4, OP_IRQ = 3'd5;
  localparam int NV = 64;
  // fields: req[82:79] op[78:76] addr[75:64] data[63:32] expect[31:0]
  localparam logic [82:0] TBL [NV] = '{
    {4'd1, OP_R,  12'h11C, 32'h0, 32'h0},          // R1
    {4'd1, OP_R,  12'h008, 32'h0, 32'h0},          // R1
    {4'd1, OP_R,  12'h12C, 32'h0, 32'h0},          // R1
    {4'd1, OP_IRQ,12'h000, 32'h0, 32'h0},          // R1
    {4'd0, OP_W,  12'h118, 32'h160, 32'h0},
    {4'd0, OP_W,  12'h094, 32'h120, 32'h0},
    {4'd0, OP_W,  12'h00C, 32'h80400100, 32'h0},
    {4'd0, OP_G0, 12'h000, 32'h20, 32'h0},
    {4'd2, OP_R,  12'h11C, 32'h0, 32'h20},         // R2 rising
    {4'd8, OP_R,  12'h008, 32'h0, 32'h100},        // R8
    {4'd9, OP_IRQ,12'h000, 32'h0, 32'h1},          // R9
    {4'd0, OP_W,  12'h11C, 32'h20, 32'h0},
    {4'd0, OP_W,  12'h008, 32'h100, 32'h0},
    {4'd6, OP_R,  12'h11C, 32'h0, 32'h0},          // R6
    {4'd9, OP_IRQ,12'h000, 32'h0, 32'h0},          // R9
    {4'd0, OP_G0, 12'h000, 32'h0, 32'h0},
    {4'd2, OP_R,  12'h11C, 32'h0, 32'h20},         // R2 falling
    {4'd0, OP_W,  12'h11C, 32'h20, 32'h0},
    {4'd0, OP_W,  12'h008, 32'h100, 32'h0},
    {4'd0, OP_G0, 12'h000, 32'h40, 32'h0},
    {4'd5, OP_R,  12'h11C, 32'h0, 32'h0},          // R5
    {4'd5, OP_R,  12'h008, 32'h0, 32'h0},          // R5
    {4'd10,OP_R,  12'h098, 32'h0, 32'h40},         // R10
    {4'd0, OP_W,  12'h120, 32'h1, 32'h0},
    {4'd0, OP_W,  12'h100, 32'h1, 32'h0},
    {4'd0, OP_G1, 12'h000, 32'h1, 32'h0},
    {4'd3, OP_R,  12'h12C, 32'h0, 32'h1},          // R3
    {4'd8, OP_R,  12'h008, 32'h0, 32'h400000},     // R8
    {4'd0, OP_W,  12'h12C, 32'h1, 32'h0},
    {4'd0, OP_W,  12'h008, 32'h400000, 32'h0},
    {4'd0, OP_G1, 12'h000, 32'h0, 32'h0},
    {4'd3, OP_R,  12'h12C, 32'h0, 32'h0},          // R3 falling ignored
    {4'd10,OP_R,  12'h104, 32'h0, 32'h0},          // R10
    {4'd0, OP_W,  12'h100, 32'h3, 32'h0},
    {4'd0, OP_G1, 12'h000, 32'h2, 32'h0},
    {4'd4, OP_R,  12'h12C, 32'h0, 32'h2},          // R4
    {4'd0, OP_W,  12'h12C, 32'h2, 32'h0},
    {4'd4, OP_R,  12'h12C, 32'h0, 32'h2},          // R4 held level
    {4'd0, OP_G1, 12'h000, 32'h0, 32'h0},
    {4'd0, OP_W,  12'h12C, 32'h2, 32'h0},
    {4'd4, OP_R,  12'h12C, 32'h0, 32'h0},          // R4
    {4'd0, OP_W,  12'h008, 32'h400000, 32'h0},
    {4'd8, OP_R,  12'h008, 32'h0, 32'h0},          // R8
    {4'd0, OP_G0, 12'h000, 32'h60, 32'h0},
    {4'd0, OP_W,  12'h11C, 32'h0, 32'h0},
    {4'd6, OP_R,  12'h11C, 32'h0, 32'h20},         // R6 zero write
    {4'd0, OP_W,  12'h11C, 32'h20, 32'h0},
    {4'd0, OP_W,  12'h008, 32'h100, 32'h0},
    {4'd6, OP_R,  12'h008, 32'h0, 32'h0},          // R6
    {4'd0, OP_HW, 12'h000, 32'h1, 32'h0},
    {4'd8, OP_R,  12'h008, 32'h0, 32'h80000000},   // R8
    {4'd9, OP_IRQ,12'h000, 32'h0, 32'h1},          // R9
    {4'd0, OP_HW, 12'h000, 32'h0, 32'h0},
    {4'd0, OP_W,  12'h008, 32'h80000000, 32'h0},
    {4'd9, OP_IRQ,12'h000, 32'h0, 32'h0},          // R9
    {4'd0, OP_W,  12'h00C, 32'hFFFFFFFF, 32'h0},
    {4'd10,OP_R,  12'h00C, 32'h0, 32'h80400100},   // R10
    {4'd10,OP_R,  12'h200, 32'h0, 32'h0},          // R10
    {4'd10,OP_R,  12'h000, 32'h0, 32'h0},          // R10
    {4'd0, OP_W,  12'h00C, 32'h0, 32'h0},
    {4'd0, OP_HW, 12'h000, 32'h1, 32'h0},
    {4'd8, OP_R,  12'h008, 32'h0, 32'h0},          // R8 gated
    {4'd0, OP_HW, 12'h000, 32'h0, 32'h0},
    {4'd10,OP_R,  12'h094, 32'h0, 32'h120}         // R10
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  // one register access, driven at a falling edge, lasting one clock
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd_check(input int req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  req;
      logic [2:0]  op;
      logic [11:0] a;
      logic [31:0] d;
      logic [31:0] e;
      {req, op, a, d, e} = TBL[i];
      reg_wen = 1'b0;
      case (op)
        OP_W:   begin reg_addr = a; reg_wdata = d; reg_wen = 1'b1; end
        OP_R:   begin reg_addr = a; #1; check(int'(req), reg_rdata, e); end
        OP_G0:  g0_evt = d;
        OP_G1:  g1_evt = d;
        OP_HW:  hw_rst_evt = d[0];
        default: begin #1; check(int'(req), {31'd0, irq}, e); end
      endcase
      @(negedge clk);
      reg_wen = 1'b0;
    end

    // R7: bit 8 rises (dual edge, enabled) in the same cycle it is cleared
    g0_evt = 32'h160;
    wr(12'h11C, 32'h100);
    rd_check(7, 12'h11C, 32'h100);
    wr(12'h11C, 32'h100);
    rd_check(6, 12'h11C, 32'h0);   // R6

    // R1: reset in the middle of activity
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_check(1, 12'h118, 32'h0);
    rd_check(1, 12'h094, 32'h0);
    rd_check(1, 12'h11C, 32'h0);
    rd_check(1, 12'h00C, 32'h0);
    #1; check(1, {31'd0, irq}, 32'h0);   // R1

    // R4: undefined code 3'b010 on bit 3 behaves as level-high
    g0_evt = 32'h0;
    wr(12'h114, 32'h8);
    wr(12'h094, 32'h8);
    g0_evt = 32'h8;
    @(negedge clk);
    rd_check(4, 12'h11C, 32'h8);
    wr(12'h11C, 32'h8);
    rd_check(4, 12'h11C, 32'h8);
    // R5 / R9: top enable still 0, so no summary and no interrupt
    rd_check(5, 12'h008, 32'h0);
    #1; check(9, {31'd0, irq}, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule